// File: doc/BRIEF.md
# Byte-lane controller for external asynchronous SRAM

The block lets on-chip logic read and write an external asynchronous static RAM of 256K words of 16 bits, one byte lane or both at a time. A request carries a word address, write data, a two-bit lane mask and a direction flag. The controller takes it when ready is high, then drives the memory's active-low chip select, write strobe, output enable and per-lane byte selects. It keeps the memory's setup, pulse-width and turnaround windows by counting clock cycles. The cycle counts come from nanosecond parameters and the clock period.

Every memory-side control is registered, so the pins change only at clock edges. Between transfers the controller parks the memory in standby with chip select and both byte selects high. During a write, output enable stays high. The write data drivers are switched off in the same cycle that the write strobe rises, and that rising edge is the edge that ends the write.

With the default 10 ns clock, a write takes 8 cycles. A read takes 8 cycles, followed by 3 cycles of bus turnaround. In this brief, transfer cycle 1 is the first cycle after the clock edge that accepts the request.

Top module: `sram_byte_ctrl`

## Requirements
- R1: Out of reset and whenever ready is high, chip select, write strobe, output enable and both byte selects are high, and the data drivers are off. During reset, ready is high and the read-valid pulse is low.
- R2: A request is taken on a clock edge where req_i and ready_o are both high. Ready then stays low for 8 cycles after a write and 11 cycles after a read. Address, mask and write data are captured at that edge, and the memory address does not change while chip select stays low.
- R3: Mask bit 0 enables the low lane (data bits 7:0, byte select 0), and mask bit 1 enables the high lane (bits 15:8, byte select 1). During transfer cycles 1 to 8, each byte select is low exactly when its mask bit is 1.
- R4: During a write, chip select is low in transfer cycles 1 to 8. The write strobe is low in cycles 3 to 7, which is at least 50 ns, and the address is stable for at least 60 ns before the strobe rises.
- R5: The write data drivers are on in cycles 4 to 7 and carry the captured data, which gives at least 30 ns of data setup. They turn off in the same cycle that the write strobe rises.
- R6: Output enable stays high for the whole write.
- R7: During a read, chip select and output enable are low and the write strobe is high in transfer cycles 1 to 8. The data is sampled at the end of cycle 8, and read-valid is a one-cycle pulse in the next cycle.
- R8: In returned read data, a lane whose mask bit is 0 reads as zero.
- R9: After a read, the controller spends 3 turnaround cycles with chip select, output enable and both byte selects high and the drivers off. The drivers are never on while the memory may still be driving, which means within 25 ns after output enable rises.
- R10: A write with mask 00 keeps both byte selects high and leaves the memory contents unchanged.
- R11: A read returns the word formed by all earlier writes, where each write updates only its enabled lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| mask_i | input | 2 | Lane mask, bit 0 = bits 7:0 |
| ready_o | output | 1 | Idle, a request may be taken |
| rdata_o | output | 16 | Read data, disabled lanes zero |
| rvalid_o | output | 1 | One-cycle read data valid |
| mem_addr_o | output | 18 | Memory address |
| mem_ce_no | output | 1 | Chip select, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_be_no | output | 2 | Byte selects, active low, bit 0 = low lane |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Data driver enable |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
The hardest situation to reach from the ports is a write that closely follows a read. There, the controller's drivers could overlap the memory's output-release window. To reach it, the bench issues reads and writes back to back, and its memory model flags any driver activity within 25 ns of output enable rising. The model also places junk on disabled lanes and returns stale data until the access time has elapsed. A lane leak or an early sample therefore shows up as a data mismatch against the scoreboard. Mixed full-word and single-lane writes to a small address set make sure that lane merges get read back.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/100ps
package sram_ctrl_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_WRITE, PH_READ, PH_TURN} phase_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic sel;
    logic drive;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_PARK = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, sel: 1'b0, drive: 1'b0};

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_seq.sv
`timescale 1ns/100ps
module sram_seq import sram_ctrl_pkg::*; #(
  parameter int WR_CYC    = 8,
  parameter int WE_START  = 2,
  parameter int WE_END    = 7,
  parameter int DRV_START = 3,
  parameter int RD_CYC    = 8,
  parameter int TA_CYC    = 3,
  localparam int CNT_W    = $clog2(imax(imax(WR_CYC, RD_CYC), TA_CYC) + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     start_we_i,
  output logic     ready_o,
  output logic     sample_o,
  output logic     sel_nxt_o,
  output bus_ctl_t ctl_o
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  bus_ctl_t         ctl_q, ctl_d;

  function automatic bus_ctl_t decode(phase_e ph, logic [CNT_W-1:0] c);
    bus_ctl_t r;
    r = CTL_PARK;
    case (ph)
      PH_WRITE: begin
        r.ce_n  = 1'b0;
        r.sel   = 1'b1;
        r.we_n  = !(int'(c) >= WE_START && int'(c) < WE_END);
        r.drive = int'(c) >= DRV_START && int'(c) < WE_END;
      end
      PH_READ: begin
        r.ce_n = 1'b0;
        r.sel  = 1'b1;
        r.oe_n = 1'b0;
      end
      default: r = CTL_PARK;
    endcase
    return r;
  endfunction

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q + 1'b1;
    case (ph_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start_i) ph_d = start_we_i ? PH_WRITE : PH_READ;
      end
      PH_WRITE: if (cnt_q == CNT_W'(WR_CYC - 1)) begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
      PH_READ: if (cnt_q == CNT_W'(RD_CYC - 1)) begin
        ph_d  = PH_TURN;
        cnt_d = '0;
      end
      default: if (cnt_q == CNT_W'(TA_CYC - 1)) begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  assign ctl_d = decode(ph_d, cnt_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      ctl_q <= CTL_PARK;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      ctl_q <= ctl_d;
    end
  end

  assign ready_o   = ph_q == PH_IDLE;
  assign sample_o  = ph_q == PH_READ && cnt_q == CNT_W'(RD_CYC - 1);
  assign sel_nxt_o = ctl_d.sel;
  assign ctl_o     = ctl_q;

  // run-length counters for pulse-width checks
  logic [CNT_W-1:0] we_run_q, drv_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_run_q  <= '0;
      drv_run_q <= '0;
    end else begin
      we_run_q  <= ctl_q.we_n  ? '0 : we_run_q + 1'b1;
      drv_run_q <= ctl_q.drive ? drv_run_q + 1'b1 : '0;
    end
  end

  p_park_when_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ctl_q.ce_n && ctl_q.we_n && ctl_q.oe_n && !ctl_q.sel && !ctl_q.drive);
  p_busy_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && ready_o |=> !ready_o);
  p_we_pulse_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_q.we_n) |-> int'(we_run_q) == WE_END - WE_START);
  p_drive_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_q.we_n) |-> !ctl_q.drive);
  p_drive_setup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctl_q.drive) |-> int'(drv_run_q) == WE_END - DRV_START);
  p_oe_high_in_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q.we_n || ctl_q.drive) |-> ctl_q.oe_n);
  p_turn_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_TURN |-> ctl_q.oe_n && !ctl_q.drive && ctl_q.ce_n);
endmodule

// File: rtl/sram_lanes.sv
`timescale 1ns/100ps
module sram_lanes #(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8,
  localparam int DW    = LANES * BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             sel_nxt_i,
  input  logic             sample_i,
  input  logic [DW-1:0]    dq_i,
  output logic [LANES-1:0] be_no,
  output logic [DW-1:0]    dq_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o
);
  logic [LANES-1:0] mask_q, be_n_q;
  logic [DW-1:0]    wdata_q, rd_q;
  logic             rvalid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic mask_nxt;
    assign mask_nxt = load_i ? mask_i[g] : mask_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[g]                  <= 1'b0;
        be_n_q[g]                  <= 1'b1;
        wdata_q[g*BYTE_W +: BYTE_W] <= '0;
        rd_q[g*BYTE_W +: BYTE_W]    <= '0;
      end else begin
        be_n_q[g] <= !(sel_nxt_i && mask_nxt);
        if (load_i) begin
          mask_q[g]                  <= mask_i[g];
          wdata_q[g*BYTE_W +: BYTE_W] <= wdata_i[g*BYTE_W +: BYTE_W];
        end
        if (sample_i)
          rd_q[g*BYTE_W +: BYTE_W] <= mask_q[g] ? dq_i[g*BYTE_W +: BYTE_W] : '0;
      end
    end

    p_dead_lane_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rvalid_o && !mask_q[g] |-> rdata_o[g*BYTE_W +: BYTE_W] == '0);
    p_lane_off_unmasked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mask_q[g] && !load_i |=> be_n_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= sample_i;
  end

  assign be_no    = be_n_q;
  assign dq_o     = wdata_q;
  assign rdata_o  = rd_q;
  assign rvalid_o = rvalid_q;

  p_rvalid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
endmodule

// File: rtl/sram_byte_ctrl.sv
`timescale 1ns/100ps
module sram_byte_ctrl import sram_ctrl_pkg::*; #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 10,
  parameter int T_WC_NS  = 70,
  parameter int T_PWE_NS = 50,
  parameter int T_AW_NS  = 60,
  parameter int T_SD_NS  = 30,
  parameter int T_RC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_HZ_NS  = 25,
  localparam int LANES   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  mask_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [LANES-1:0]  mem_be_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int WC_CYC    = ceil_div(T_WC_NS, CLK_NS);
  localparam int PWE_CYC   = ceil_div(T_PWE_NS, CLK_NS);
  localparam int AW_CYC    = ceil_div(T_AW_NS, CLK_NS);
  localparam int SD_CYC    = ceil_div(T_SD_NS, CLK_NS) + 1;
  localparam int WS_MIN    = imax(1, AW_CYC - PWE_CYC);
  localparam int WR_CYC    = imax(WC_CYC + 1, WS_MIN + PWE_CYC + 1);
  localparam int WE_START  = WR_CYC - 1 - PWE_CYC;
  localparam int WE_END    = WE_START + PWE_CYC;
  localparam int DRV_START = imax(1, WE_END - SD_CYC);
  localparam int RD_CYC    = imax(ceil_div(T_RC_NS, CLK_NS), ceil_div(T_AA_NS, CLK_NS)) + 1;
  localparam int TA_CYC    = imax(1, ceil_div(T_HZ_NS, CLK_NS));

  logic              accept, sample, sel_nxt;
  bus_ctl_t          ctl;
  logic [ADDR_W-1:0] addr_q;

  assign accept = req_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (accept) addr_q <= addr_i;
  end

  sram_seq #(
    .WR_CYC   (WR_CYC),
    .WE_START (WE_START),
    .WE_END   (WE_END),
    .DRV_START(DRV_START),
    .RD_CYC   (RD_CYC),
    .TA_CYC   (TA_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .start_we_i(we_i),
    .ready_o   (ready_o),
    .sample_o  (sample),
    .sel_nxt_o (sel_nxt),
    .ctl_o     (ctl)
  );

  sram_lanes #(
    .LANES (LANES),
    .BYTE_W(8)
  ) u_lanes (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .mask_i   (mask_i),
    .wdata_i  (wdata_i),
    .sel_nxt_i(sel_nxt),
    .sample_i (sample),
    .dq_i     (mem_dq_i),
    .be_no    (mem_be_no),
    .dq_o     (mem_dq_o),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign mem_addr_o  = addr_q;
  assign mem_ce_no   = ctl.ce_n;
  assign mem_we_no   = ctl.we_n;
  assign mem_oe_no   = ctl.oe_n;
  assign mem_dq_oe_o = ctl.drive;

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no && !$past(mem_ce_no) |-> $stable(mem_addr_o));
  p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o && $past(mem_dq_oe_o) |-> $stable(mem_dq_o));
  p_no_lanes_no_select_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && mask_i == '0 |=> mem_be_no == '1);
endmodule

// File: tb/sim_sram_byte_ctrl.sv
`timescale 1ns/100ps
module sim_sram_byte_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  mask = '0;
  logic        ready_o, rvalid_o;
  logic [15:0] rdata_o;
  logic [17:0] mem_addr_o;
  logic        mem_ce_no, mem_we_no, mem_oe_no, mem_dq_oe_o;
  logic [1:0]  mem_be_no;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = 16'hC3C3;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit armed = 1'b0;

  sram_byte_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .mask_i(mask), .ready_o(ready_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .mem_addr_o(mem_addr_o), .mem_ce_no(mem_ce_no),
    .mem_we_no(mem_we_no), .mem_oe_no(mem_oe_no), .mem_be_no(mem_be_no),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural memory ----------------
  logic [15:0] mem [int];
  realtime t_chg = 0, t_addr = 0, t_we_fall = 0, t_oe_rise = -100, t_data_ok = 0;
  logic [15:0] drv_dq = '0, prev_dq = '0;
  bit drv_on = 1'b0, prev_oe = 1'b0;

  always @(mem_addr_o or mem_ce_no or mem_oe_no or mem_we_no or mem_be_no) t_chg = $realtime;
  always @(mem_addr_o) t_addr = $realtime;
  always @(negedge mem_we_no) t_we_fall = $realtime;
  always @(posedge mem_oe_no) t_oe_rise = $realtime;

  function automatic logic [15:0] rd_word(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  initial begin
    #0.5;
    forever begin
      #1;
      if (mem_dq_oe_o && (!prev_oe || mem_dq_o != prev_dq)) t_data_ok = $realtime;
      prev_oe = mem_dq_oe_o;
      prev_dq = mem_dq_o;
      drv_on  = mem_dq_oe_o;
      if (mem_dq_oe_o) drv_dq = mem_dq_o;
      if (!mem_ce_no && mem_we_no && !mem_oe_no) begin
        if ($realtime - t_chg >= 70.0) begin
          logic [15:0] w;
          w = rd_word(int'(mem_addr_o));
          mem_dq_i = {mem_be_no[1] ? 8'hA5 : w[15:8], mem_be_no[0] ? 8'hA5 : w[7:0]};
        end else mem_dq_i = 16'h5A5A;
      end else mem_dq_i = 16'hC3C3;
      if (armed && mem_dq_oe_o)
        chk(!(!mem_ce_no && mem_we_no && mem_be_no != 2'b11 &&
              (!mem_oe_no || $realtime - t_oe_rise < 25.0)),
            "R9", "driver overlaps memory output window", {31'd0, mem_oe_no}, 32'd1);
    end
  end

  always @(posedge mem_we_no) begin
    if (armed && !mem_ce_no && mem_be_no != 2'b11) begin
      logic [15:0] w;
      chk($realtime - t_we_fall >= 50.0, "R4", "write strobe width ns",
          32'($rtoi($realtime - t_we_fall)), 32'd50);
      chk($realtime - t_addr >= 60.0, "R4", "address setup to strobe rise ns",
          32'($rtoi($realtime - t_addr)), 32'd60);
      chk(drv_on && $realtime - t_data_ok >= 29.0, "R5", "data setup to strobe rise ns",
          32'($rtoi($realtime - t_data_ok)), 32'd30);
      chk(mem_oe_no == 1'b1, "R6", "output enable at write end", {31'd0, mem_oe_no}, 32'd1);
      w = rd_word(int'(mem_addr_o));
      if (!mem_be_no[0]) w[7:0]  = drv_dq[7:0];
      if (!mem_be_no[1]) w[15:8] = drv_dq[15:8];
      mem[int'(mem_addr_o)] = w;
    end
  end

  // ---------------- cycle reference model ----------------
  logic [15:0] sb [int];
  bit          exp_ready = 1'b1, exp_rvalid = 1'b0;
  logic [15:0] exp_rdata = '0;
  int          busy = 0, rd_left = 0, cyc = 0;
  bit          op_we = 1'b0;
  logic [1:0]  op_mask = '0;
  logic [15:0] op_wdata = '0;

  function automatic logic [15:0] sb_word(input int a);
    return sb.exists(a) ? sb[a] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      exp_ready = 1'b1; exp_rvalid = 1'b0; busy = 0; rd_left = 0; cyc = 0;
    end else begin
      bit acc;
      acc = exp_ready && req;
      if (busy > 0) busy--;
      if (rd_left > 0) begin rd_left--; exp_rvalid = (rd_left == 0); end
      else exp_rvalid = 1'b0;
      cyc++;
      if (acc) begin
        logic [15:0] w;
        cyc = 0; op_we = we; op_mask = mask; op_wdata = wdata;
        w = sb_word(int'(addr));
        if (we) begin
          if (mask[0]) w[7:0]  = wdata[7:0];
          if (mask[1]) w[15:8] = wdata[15:8];
          sb[int'(addr)] = w;
          busy = 8;
        end else begin
          exp_rdata = {mask[1] ? w[15:8] : 8'h00, mask[0] ? w[7:0] : 8'h00};
          busy = 11;
          rd_left = 8;
        end
      end
      exp_ready = (busy == 0);
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk(ready_o == exp_ready, "R2", "ready", {31'd0, ready_o}, {31'd0, exp_ready});
      chk(rvalid_o == exp_rvalid, "R7", "read valid pulse", {31'd0, rvalid_o}, {31'd0, exp_rvalid});
      if (exp_rvalid)
        chk(rdata_o == exp_rdata, (op_mask != 2'b11) ? "R8" : "R11", "read data",
            {16'd0, rdata_o}, {16'd0, exp_rdata});
      if (exp_ready)
        chk({mem_ce_no, mem_we_no, mem_oe_no, mem_be_no, mem_dq_oe_o} == 6'b111110, "R1",
            "parked pins", {26'd0, mem_ce_no, mem_we_no, mem_oe_no, mem_be_no, mem_dq_oe_o},
            32'b111110);
      else if (op_we) begin
        chk(mem_be_no == ~op_mask, (op_mask == 2'b00) ? "R10" : "R3", "write byte selects",
            {30'd0, mem_be_no}, {30'd0, ~op_mask});
        chk(mem_we_no == !(cyc >= 2 && cyc < 7), "R4", "write strobe pattern",
            {31'd0, mem_we_no}, {31'd0, !(cyc >= 2 && cyc < 7)});
        chk(mem_dq_oe_o == (cyc >= 3 && cyc < 7), "R5", "driver window",
            {31'd0, mem_dq_oe_o}, {31'd0, (cyc >= 3 && cyc < 7)});
        chk(mem_oe_no && !mem_ce_no, "R6", "oe high and ce low in write",
            {30'd0, mem_oe_no, mem_ce_no}, 32'b10);
        if (mem_dq_oe_o)
          chk(mem_dq_o == op_wdata, "R5", "driven data", {16'd0, mem_dq_o}, {16'd0, op_wdata});
      end else if (cyc < 8) begin
        chk({mem_ce_no, mem_we_no, mem_oe_no, mem_dq_oe_o} == 4'b0100, "R7", "read controls",
            {28'd0, mem_ce_no, mem_we_no, mem_oe_no, mem_dq_oe_o}, 32'b0100);
        chk(mem_be_no == ~op_mask, "R3", "read byte selects", {30'd0, mem_be_no}, {30'd0, ~op_mask});
      end else
        chk({mem_ce_no, mem_oe_no, mem_dq_oe_o, mem_be_no} == 5'b11011, "R9", "turnaround pins",
            {27'd0, mem_ce_no, mem_oe_no, mem_dq_oe_o, mem_be_no}, 32'b11011);
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(input bit w, input logic [17:0] a, input logic [15:0] d,
                    input logic [1:0] m, input bit keep);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; mask = m;
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    if (!keep) req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({ready_o, rvalid_o, mem_ce_no, mem_we_no, mem_oe_no, mem_be_no, mem_dq_oe_o} == 8'b10111110,
        "R1", "reset state",
        {24'd0, ready_o, rvalid_o, mem_ce_no, mem_we_no, mem_oe_no, mem_be_no, mem_dq_oe_o},
        32'b10111110);
    rst_ni = 1'b1;
    armed = 1'b1;

    op(1, 18'h00010, 16'h1234, 2'b11, 0);   // full word
    op(1, 18'h00020, 16'hFFAB, 2'b01, 0);   // low lane only
    op(1, 18'h00010, 16'hCD99, 2'b10, 0);   // high lane merge
    op(0, 18'h00010, 16'h0000, 2'b11, 0);   // R11 expect CD34
    op(0, 18'h00010, 16'h0000, 2'b01, 0);   // R8 expect 0034
    op(0, 18'h00010, 16'h0000, 2'b10, 0);   // R8 expect CD00
    op(0, 18'h00020, 16'h0000, 2'b11, 0);   // expect 00AB
    op(1, 18'h00020, 16'h7777, 2'b00, 0);   // R10 no lanes
    op(0, 18'h00020, 16'h0000, 2'b11, 0);   // still 00AB
    op(1, 18'h3FFFF, 16'hBEEF, 2'b11, 1);   // top address, req held
    op(0, 18'h3FFFF, 16'h0000, 2'b11, 1);   // read straight after write
    op(1, 18'h3FFFF, 16'h00C1, 2'b01, 1);   // write straight after read (R9)
    op(0, 18'h3FFFF, 16'h0000, 2'b11, 0);

    begin
      logic [31:0] lf;
      lf = 32'hACE1_2345;
      for (int i = 0; i < 80; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        op(lf[3], 18'h00100 + 18'(lf[6:4]), lf[23:8], lf[25:24], lf[26]);
      end
    end
    req = 1'b0;
    repeat (20) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule